// File: doc/BRIEF.md
# Virtual-8086 Software Interrupt Dispatcher

This block decides what happens when a virtual-8086 task executes a software interrupt instruction. From the extension enable bit, the two-bit I/O privilege level and one bit of a 256-entry per-vector redirection map, it picks one of three outcomes. The first is to hand the interrupt to the 32-bit protected-mode handler. The second is to raise a general-protection fault. The third is to redirect the interrupt to a real-format handler inside the task itself. The first two outcomes are only reported, so the gate logic around the block carries them out.

When the interrupt is redirected, the block does the work itself. It pushes a three-word frame (flags, code segment, instruction pointer) onto the 16-bit task stack through a word-wide memory port. It then fetches the far pointer for the vector from the table at address 0. Finally it reports the new CS:IP, the new SP, the adjusted flags and the virtual interrupt flag. The frame has two formats, and the I/O privilege level chooses between them. When the level is 3, the pushed flags hide privilege information. When it is below 3, the pushed interrupt flag is taken from the virtual copy, VIF.

The host pulses `start` for one cycle with the inputs valid in that cycle, and the block captures them. It reports the result on a one-cycle `done` pulse. The result outputs keep their value until the next result is reported.

Top module: `swint_dispatch`

## Requirements
- R1: With vme=0 and iopl=3, done pulses one cycle after start and reports action 1 (protected-mode handler). new_cs, new_ip, new_sp, new_flags and new_vif equal the values captured at start, and no memory access is made.
- R2: With vme=0 and iopl below 3, done pulses one cycle after start and reports action 2 (general-protection fault), with the same pass-through of values and no memory access.
- R3: With vme=1 and redirection bit n set, the action is 1 when iopl=3 and 2 when iopl is below 3. With vme=1 and the bit clear, the action is 3 (redirect).
- R4: Bit n of redir_map (bit index equal to the vector number) is the only bit that affects the outcome for vector n.
- R5: In a redirect with iopl=3, the pushed flags have NT (bit 14) and IOPL (bits 13:12) cleared. The reported new_flags have IF (bit 9) and TF (bit 8) cleared, and new_vif equals the captured VIF.
- R6: In a redirect with iopl below 3, the pushed flags have IOPL set to 3 and bit 9 replaced by VIF. The reported new_flags have only TF cleared, and new_vif is 0.
- R7: The redirect pushes flags, then CS, then IP, at byte addresses SS*16 + ((SP-2k) mod 2^16) for k = 1, 2, 3, using a 21-bit address. The reported new_sp is (SP-6) mod 2^16.
- R8: The redirect reads the new IP from byte address 4n and the new CS from 4n+2. Read data is expected on mem_rdata in the cycle after the read strobe.
- R9: A redirect asserts mem_we in cycles 1 to 3 after start and mem_re in cycles 4 and 5, and pulses done in cycle 7. mem_we and mem_re are never high together, and done lasts exactly one cycle.
- R10: After reset, done, mem_we and mem_re are low, action is 0 and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Software interrupt request; the other inputs are captured with it |
| vec_n | input | 8 | Interrupt vector number |
| vme | input | 1 | Virtual-8086 extensions enable |
| iopl | input | 2 | I/O privilege level |
| vif | input | 1 | Virtual interrupt flag |
| flags_in | input | 16 | Current FLAGS word |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Return instruction pointer |
| ss_in | input | 16 | Stack segment |
| sp_in | input | 16 | Stack pointer |
| redir_map | input | 256 | Per-vector redirection bits |
| mem_we | output | 1 | Word write strobe |
| mem_re | output | 1 | Word read strobe |
| mem_addr | output | 21 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after mem_re |
| done | output | 1 | Result valid pulse |
| action | output | 2 | 1 handler, 2 fault, 3 redirect |
| new_cs | output | 16 | Resulting code segment |
| new_ip | output | 16 | Resulting instruction pointer |
| new_sp | output | 16 | Resulting stack pointer |
| new_flags | output | 16 | Resulting FLAGS |
| new_vif | output | 1 | Resulting virtual interrupt flag |

## Verification
The hardest situation to reach is a redirect whose stack addresses wrap, where SP is below 6. In that case the 16-bit offset wraps while the segment base still adds in, and the frame is split across the top and the bottom of the 64 KiB window. Directed cases therefore set SP to 0, 2 and 4 with a non-zero SS. Randomised cases then mix every combination of vme, iopl and map bit. For each one, the neighbouring map bit is set to the opposite value, so an error in indexing the map shows up as a wrong action.

// File: rtl/swint_pkg.sv
package swint_pkg;
  localparam int WORD_W   = 16;
  localparam int SEG_SH   = 4;
  localparam int ADDR_W   = WORD_W + SEG_SH + 1;
  localparam int FL_TF    = 8;
  localparam int FL_IF    = 9;
  localparam int FL_PL_LO = 12;
  localparam int FL_PL_HI = 13;
  localparam int FL_NT    = 14;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_PMODE = 2'd1,
    ACT_GPF   = 2'd2,
    ACT_REDIR = 2'd3
  } act_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PFL, S_PCS, S_PIP, S_RIP, S_RCS, S_FIN
  } st_e;

  // segment:offset to linear byte address, no 20-bit wrap
  function automatic logic [ADDR_W-1:0] lin_addr(input logic [WORD_W-1:0] seg,
                                                 input logic [WORD_W-1:0] off);
    return ADDR_W'({seg, {SEG_SH{1'b0}}}) + ADDR_W'(off);
  endfunction

  // stack pointer after k word pushes, modulo 2^16
  function automatic logic [WORD_W-1:0] sp_after(input logic [WORD_W-1:0] sp,
                                                 input int unsigned k);
    return sp - WORD_W'(2 * k);
  endfunction

  function automatic logic [WORD_W-1:0] frame_word(input logic [WORD_W-1:0] fl,
                                                   input logic pl3, input logic vf);
    logic [WORD_W-1:0] r;
    r = fl;
    if (pl3) begin
      r[FL_NT] = 1'b0;
      r[FL_PL_HI:FL_PL_LO] = 2'b00;
    end else begin
      r[FL_PL_HI:FL_PL_LO] = 2'b11;
      r[FL_IF] = vf;
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] live_flags(input logic [WORD_W-1:0] fl,
                                                   input logic pl3);
    logic [WORD_W-1:0] r;
    r = fl;
    r[FL_TF] = 1'b0;
    if (pl3) r[FL_IF] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/swint_decide.sv
module swint_decide
  import swint_pkg::*;
#(
  parameter int VEC_W = 8,
  localparam int VECS = 1 << VEC_W
) (
  input  logic             vme,
  input  logic [1:0]       iopl,
  input  logic [VEC_W-1:0] vec,
  input  logic [VECS-1:0]  redir_map,
  output act_e             act
);
  logic map_bit;
  logic pl3;

  assign map_bit = redir_map[vec];
  assign pl3     = (iopl == 2'b11);

  always_comb begin
    if (vme && !map_bit) act = ACT_REDIR;
    else if (pl3)        act = ACT_PMODE;
    else                 act = ACT_GPF;
  end
endmodule

// File: rtl/swint_frame.sv
module swint_frame
  import swint_pkg::*;
(
  input  logic [WORD_W-1:0] fl,
  input  logic              pl3,
  input  logic              vf,
  output logic [WORD_W-1:0] push_fl,
  output logic [WORD_W-1:0] next_fl,
  output logic              next_vf
);
  assign push_fl = frame_word(fl, pl3, vf);
  assign next_fl = live_flags(fl, pl3);
  assign next_vf = pl3 ? vf : 1'b0;
endmodule

// File: rtl/swint_seq.sv
module swint_seq
  import swint_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  act_e              act_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              pl3_i,
  input  logic              vif_i,
  input  logic [WORD_W-1:0] flags_i,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic [WORD_W-1:0] ss_i,
  input  logic [WORD_W-1:0] sp_i,
  output logic [WORD_W-1:0] lat_fl,
  output logic              lat_pl3,
  output logic              lat_vif,
  input  logic [WORD_W-1:0] push_fl,
  input  logic [WORD_W-1:0] next_fl,
  input  logic              next_vf,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              accept,
  output logic              done,
  output act_e              res_act,
  output logic [WORD_W-1:0] res_cs,
  output logic [WORD_W-1:0] res_ip,
  output logic [WORD_W-1:0] res_sp,
  output logic [WORD_W-1:0] res_fl,
  output logic              res_vif
);
  st_e st;
  logic [VEC_W-1:0]  vec_q;
  logic [WORD_W-1:0] cs_q, ip_q, ss_q, sp_q, vip_q;

  assign accept = (st == S_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      vec_q <= '0; cs_q <= '0; ip_q <= '0; ss_q <= '0; sp_q <= '0; vip_q <= '0;
      lat_fl <= '0; lat_pl3 <= 1'b0; lat_vif <= 1'b0;
      done <= 1'b0; res_act <= ACT_NONE;
      res_cs <= '0; res_ip <= '0; res_sp <= '0; res_fl <= '0; res_vif <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          vec_q <= vec_i; cs_q <= cs_i; ip_q <= ip_i; ss_q <= ss_i; sp_q <= sp_i;
          lat_fl <= flags_i; lat_pl3 <= pl3_i; lat_vif <= vif_i;
          if (act_i == ACT_REDIR) begin
            st <= S_PFL;
          end else begin
            res_act <= act_i;
            res_cs <= cs_i; res_ip <= ip_i; res_sp <= sp_i;
            res_fl <= flags_i; res_vif <= vif_i;
            done <= 1'b1;
          end
        end
        S_PFL: st <= S_PCS;
        S_PCS: st <= S_PIP;
        S_PIP: st <= S_RIP;
        S_RIP: st <= S_RCS;
        S_RCS: begin
          vip_q <= mem_rdata;
          st <= S_FIN;
        end
        S_FIN: begin
          res_act <= ACT_REDIR;
          res_cs  <= mem_rdata;
          res_ip  <= vip_q;
          res_sp  <= sp_after(sp_q, 3);
          res_fl  <= next_fl;
          res_vif <= next_vf;
          done    <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we = 1'b0;
    mem_re = 1'b0;
    mem_addr = '0;
    mem_wdata = '0;
    case (st)
      S_PFL: begin mem_we = 1'b1; mem_addr = lin_addr(ss_q, sp_after(sp_q, 1)); mem_wdata = push_fl; end
      S_PCS: begin mem_we = 1'b1; mem_addr = lin_addr(ss_q, sp_after(sp_q, 2)); mem_wdata = cs_q; end
      S_PIP: begin mem_we = 1'b1; mem_addr = lin_addr(ss_q, sp_after(sp_q, 3)); mem_wdata = ip_q; end
      S_RIP: begin mem_re = 1'b1; mem_addr = ADDR_W'({vec_q, 2'b00}); end
      S_RCS: begin mem_re = 1'b1; mem_addr = ADDR_W'({vec_q, 2'b10}); end
      default: ;
    endcase
  end
endmodule

// File: rtl/swint_dispatch.sv
module swint_dispatch
  import swint_pkg::*;
#(
  parameter int VEC_W = 8,
  localparam int VECS = 1 << VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VEC_W-1:0]  vec_n,
  input  logic              vme,
  input  logic [1:0]        iopl,
  input  logic              vif,
  input  logic [WORD_W-1:0] flags_in,
  input  logic [WORD_W-1:0] cs_in,
  input  logic [WORD_W-1:0] ip_in,
  input  logic [WORD_W-1:0] ss_in,
  input  logic [WORD_W-1:0] sp_in,
  input  logic [VECS-1:0]   redir_map,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic [1:0]        action,
  output logic [WORD_W-1:0] new_cs,
  output logic [WORD_W-1:0] new_ip,
  output logic [WORD_W-1:0] new_sp,
  output logic [WORD_W-1:0] new_flags,
  output logic              new_vif
);
  act_e              pick_w;
  act_e              res_act_w;
  logic              accept_w;
  logic              accept_redir_w;
  logic [WORD_W-1:0] lat_fl_w, push_fl_w, next_fl_w;
  logic              lat_pl3_w, lat_vif_w, next_vf_w;

  swint_decide #(.VEC_W(VEC_W)) u_decide (
    .vme(vme), .iopl(iopl), .vec(vec_n), .redir_map(redir_map), .act(pick_w)
  );

  swint_frame u_frame (
    .fl(lat_fl_w), .pl3(lat_pl3_w), .vf(lat_vif_w),
    .push_fl(push_fl_w), .next_fl(next_fl_w), .next_vf(next_vf_w)
  );

  swint_seq #(.VEC_W(VEC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .act_i(pick_w), .vec_i(vec_n),
    .pl3_i(iopl == 2'b11), .vif_i(vif), .flags_i(flags_in), .cs_i(cs_in),
    .ip_i(ip_in), .ss_i(ss_in), .sp_i(sp_in),
    .lat_fl(lat_fl_w), .lat_pl3(lat_pl3_w), .lat_vif(lat_vif_w),
    .push_fl(push_fl_w), .next_fl(next_fl_w), .next_vf(next_vf_w),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .accept(accept_w), .done(done), .res_act(res_act_w),
    .res_cs(new_cs), .res_ip(new_ip), .res_sp(new_sp), .res_fl(new_flags),
    .res_vif(new_vif)
  );

  assign action         = res_act_w;
  assign accept_redir_w = accept_w && (pick_w == ACT_REDIR);
endmodule

// File: rtl/swint_chk.sv
module swint_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_we,
  input logic        mem_re,
  input logic        done,
  input logic [1:0]  action,
  input logic [15:0] new_flags,
  input logic        new_vif,
  input logic        accept_w,
  input logic        accept_redir_w,
  input logic        lat_pl3_w
);
  assert_port_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fast_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !accept_redir_w) |=> (done && !mem_we && !mem_re));

  assert_push_begins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_redir_w |=> (mem_we && !done));

  assert_trap_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && action == 2'd3) |-> !new_flags[8]);

  assert_vif_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && action == 2'd3 && !lat_pl3_w) |-> !new_vif);

  assert_valid_action_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (action != 2'd0));
endmodule

bind swint_dispatch swint_chk u_chk (.*);

// File: tb/tb_swint_dispatch.sv
`timescale 1ns/1ps
module tb_swint_dispatch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] vec_n = '0;
  logic vme = 1'b0;
  logic [1:0] iopl = '0;
  logic vif = 1'b0;
  logic [15:0] flags_in = '0, cs_in = '0, ip_in = '0, ss_in = '0, sp_in = '0;
  logic [255:0] redir_map = '0;
  logic mem_we, mem_re, done, new_vif;
  logic [20:0] mem_addr;
  logic [15:0] mem_wdata, new_cs, new_ip, new_sp, new_flags;
  logic [15:0] mem_rdata = '0;
  logic [1:0] action;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] mem [int];

  always #2 clk = ~clk;

  swint_dispatch dut (.*);

  always @(posedge clk) begin
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", rq, got, exp, $time);
    end
  endtask

  task automatic run_case(input logic [7:0] n, input bit v, input logic [1:0] pl,
                          input bit vf, input logic [15:0] fl, input logic [15:0] cs,
                          input logic [15:0] ip, input logic [15:0] ss,
                          input logic [15:0] sp, input bit mbit);
    int exp_act, lat;
    logic [15:0] tip, tcs, pf, nf, sp_end;
    bit nvf;
    logic [20:0] waddr[3];
    logic [15:0] wdat[3];
    tip = 16'($urandom);
    tcs = 16'($urandom);
    mem[4 * int'(n)] = tip;
    mem[4 * int'(n) + 2] = tcs;
    if (v && !mbit) exp_act = 3;
    else exp_act = (pl == 2'd3) ? 1 : 2;
    lat = (exp_act == 3) ? 7 : 1;
    if (pl == 2'd3) begin
      pf = fl & 16'h8FFF;
      nf = fl & 16'hFCFF;
      nvf = vf;
    end else begin
      pf = ((fl | 16'h3000) & 16'hFDFF) | (vf ? 16'h0200 : 16'h0000);
      nf = fl & 16'hFEFF;
      nvf = 1'b0;
    end
    wdat[0] = pf; wdat[1] = cs; wdat[2] = ip;
    for (int k = 0; k < 3; k++) waddr[k] = 21'(ss) * 21'd16 + 21'(16'(sp - 16'(2 * (k + 1))));
    sp_end = sp - 16'd6;

    @(negedge clk);
    vec_n = n; vme = v; iopl = pl; vif = vf; flags_in = fl; cs_in = cs; ip_in = ip;
    ss_in = ss; sp_in = sp;
    redir_map = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    redir_map[n] = mbit;
    redir_map[n ^ 8'd1] = ~mbit;  // R4: neighbour bit differs
    start = 1'b1;
    for (int k = 1; k <= lat + 1; k++) begin
      @(negedge clk);
      start = 1'b0;
      chk(done == (k == lat), "R9 done timing", 32'(done), 32'(k == lat));
      chk(mem_we == (exp_act == 3 && k >= 1 && k <= 3), "R9 write window", 32'(mem_we), 32'(exp_act == 3 && k <= 3));
      chk(mem_re == (exp_act == 3 && k >= 4 && k <= 5), "R8 read window", 32'(mem_re), 32'(exp_act == 3 && k >= 4 && k <= 5));
      if (exp_act == 3 && k <= 3 && mem_we) begin
        chk(mem_addr == waddr[k-1], "R7 push address", 32'(mem_addr), 32'(waddr[k-1]));
        chk(mem_wdata == wdat[k-1], (k == 1) ? "R5/R6 pushed flags" : "R7 pushed CS:IP", 32'(mem_wdata), 32'(wdat[k-1]));
      end
      if (exp_act == 3 && (k == 4 || k == 5) && mem_re)
        chk(mem_addr == 21'(4 * int'(n) + 2 * (k - 4)), "R8 vector address", 32'(mem_addr), 32'(4 * int'(n) + 2 * (k - 4)));
      if (k == lat) begin
        chk(int'(action) == exp_act, "R1/R2/R3/R4 action", 32'(action), 32'(exp_act));
        if (exp_act == 3) begin
          chk(new_ip == tip, "R8 new IP", 32'(new_ip), 32'(tip));
          chk(new_cs == tcs, "R8 new CS", 32'(new_cs), 32'(tcs));
          chk(new_sp == sp_end, "R7 new SP", 32'(new_sp), 32'(sp_end));
          chk(new_flags == nf, "R5/R6 new flags", 32'(new_flags), 32'(nf));
          chk(new_vif == nvf, "R5/R6 new VIF", 32'(new_vif), 32'(nvf));
        end else begin
          chk({new_cs, new_ip} == {cs, ip}, "R1/R2 CS:IP unchanged", {new_cs, new_ip}, {cs, ip});
          chk(new_sp == sp && new_flags == fl && new_vif == vf, "R1/R2 SP/flags unchanged",
              {new_sp, new_flags}, {sp, fl});
        end
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !mem_we && !mem_re, "R10 reset strobes", {done, mem_we, mem_re}, 0);
    chk(action == 2'd0, "R10 reset action", 32'(action), 0);
    chk({new_cs, new_ip, new_sp, new_flags} == '0 && !new_vif, "R10 reset results", 32'(new_sp), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1, R2 plain decisions
    run_case(8'h21, 1'b0, 2'd3, 1'b0, 16'h7302, 16'h1000, 16'h0100, 16'h2000, 16'h0800, 1'b0);
    run_case(8'h10, 1'b0, 2'd0, 1'b1, 16'h0202, 16'h1234, 16'h5678, 16'h2000, 16'h0800, 1'b0);
    // R3 map bit set
    run_case(8'h13, 1'b1, 2'd3, 1'b0, 16'h4246, 16'hABCD, 16'h0010, 16'h3000, 16'h0100, 1'b1);
    run_case(8'h13, 1'b1, 2'd2, 1'b1, 16'h4246, 16'hABCD, 16'h0010, 16'h3000, 16'h0100, 1'b1);
    // R5 and R6 redirect formats
    run_case(8'h21, 1'b1, 2'd3, 1'b1, 16'h7346, 16'h0700, 16'h0123, 16'h9000, 16'hFFF0, 1'b0);
    run_case(8'h21, 1'b1, 2'd1, 1'b1, 16'h4146, 16'h0700, 16'h0123, 16'h9000, 16'hFFF0, 1'b0);
    run_case(8'h21, 1'b1, 2'd0, 1'b0, 16'h0346, 16'h0700, 16'h0123, 16'h9000, 16'hFFF0, 1'b0);
    // R7 stack wrap with high segment; R8 extreme vectors
    run_case(8'hFF, 1'b1, 2'd3, 1'b0, 16'hFFFF, 16'h0001, 16'h0002, 16'hFFFF, 16'h0000, 1'b0);
    run_case(8'h00, 1'b1, 2'd2, 1'b1, 16'h0000, 16'h0003, 16'h0004, 16'hF000, 16'h0002, 1'b0);
    run_case(8'h80, 1'b1, 2'd3, 1'b1, 16'h1234, 16'h0005, 16'h0006, 16'h0040, 16'h0004, 1'b0);
    // mixed random cases
    for (int i = 0; i < 60; i++)
      run_case(8'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 16'($urandom),
               16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule